// File: doc/BRIEF.md
# Top-Block ROM Select with Default RAM and Override Holes

This decoder drives two active-low chip selects across a 1 MB memory space. The ROM select covers a block of programmable size that always ends at the last byte of the space. The block size is held in a small register written through a strobe and a one-hot size field. A reset leaves the block at its smallest size.

RAM has no range register. Every memory cycle that misses the ROM block and is not claimed by a peripheral selects RAM. So the RAM map grows or shrinks with the ROM block size and needs no configuration of its own. Memory-mapped peripherals claim an address by pulling one of seven per-slot override lines low, or by pulling one shared open-collector style line low. A claim makes a hole in RAM at whatever address the peripheral decodes. Selects are only given during memory cycles, never during I/O cycles.

Top module: `msel_decoder`

## Requirements
- R1: After reset the ROM block is 1 KB: addresses 0xFFC00 to 0xFFFFF select ROM and 0xFFBFF selects RAM.
- R2: During a memory cycle `rom_cs_n` is low exactly when `addr` is greater than or equal to 2^20 minus the programmed block size.
- R3: `cfg_size` is one-hot: bit k set means a block of 1 KB shifted left by k, for k from 0 (1 KB) to 8 (256 KB). A write with `cfg_wr` high is captured at the clock edge and governs decoding from then on.
- R4: A write whose `cfg_size` has no bit set, or more than one bit set, is ignored and the previous block size stays in force.
- R5: During a memory cycle with no override asserted, `ram_cs_n` is low for every address outside the ROM block.
- R6: Each of the seven `slot_ovr_n` inputs, when low, forces `ram_cs_n` high.
- R7: `shared_ovr_n` low forces `ram_cs_n` high.
- R8: Overrides have no effect on `rom_cs_n`. An address inside the ROM block still selects ROM with every override low.
- R9: Both selects stay high when `mem_strobe` is low or `io_cycle` is high.
- R10: `rom_cs_n` and `ram_cs_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the size register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the block-size register |
| cfg_size | input | 9 | One-hot block size, bit k = 1 KB << k |
| mem_strobe | input | 1 | High while a memory cycle is active |
| io_cycle | input | 1 | High during an I/O cycle |
| addr | input | 20 | Byte address of the current cycle |
| slot_ovr_n | input | 7 | Per-slot peripheral claims, active low |
| shared_ovr_n | input | 1 | Shared peripheral claim line, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |

## Verification
The assertions assume the address, the cycle-type inputs and the override lines are steady across each clock edge. The assertion that overrides leave the ROM select alone also assumes that when only overrides change between edges, the address and size do not. The bench drives every input on the falling edge and samples on the same half-cycle, so each vector is settled before the edge the properties sample. It also changes overrides in their own vectors, apart from address changes.

// File: rtl/msel_pkg.sv
package msel_pkg;

   localparam int unsigned MSEL_ADDR_W    = 20;
   localparam int unsigned MSEL_MIN_SHIFT = 10;
   localparam int unsigned MSEL_SIZE_W    = 9;
   localparam int unsigned MSEL_SLOTS     = 7;

   typedef struct packed {
      logic rom_n;
      logic ram_n;
   } msel_cs_t;

endpackage

// File: rtl/msel_size_reg.sv
module msel_size_reg #(
   parameter int unsigned SIZE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SIZE_W-1:0] wr_data,
   output logic [SIZE_W-1:0] size_q
);

   localparam logic [SIZE_W-1:0] RESET_SIZE = SIZE_W'(1);

   generate
      if (SIZE_W < 1) begin : g_bad_width
         $error("msel_size_reg: SIZE_W must be at least 1");
      end
   endgenerate

   logic legal;
   assign legal = $onehot(wr_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         size_q <= RESET_SIZE;
      else if (wr_en && legal)
         size_q <= wr_data;
   end

   assert_size_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(size_q));

   assert_illegal_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !$onehot(wr_data)) |=> $stable(size_q));

endmodule

// File: rtl/msel_rom_match.sv
module msel_rom_match #(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned MIN_SHIFT = 10,
   parameter int unsigned SIZE_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size_q,
   output logic              hit
);

   localparam int unsigned TOP_BIT = MIN_SHIFT + SIZE_W;

   generate
      if (TOP_BIT > ADDR_W) begin : g_bad_span
         $error("msel_rom_match: largest block exceeds the address space");
      end
   endgenerate

   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] low_bits;

   assign span     = ADDR_W'(size_q) << MIN_SHIFT;
   assign low_bits = span - ADDR_W'(1);
   assign hit      = &(addr | low_bits);

   logic [ADDR_W:0] base_ext;
   assign base_ext = (ADDR_W+1)'(1) << ADDR_W;

   assert_rom_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit == ({1'b0, addr} >= (base_ext - {1'b0, span})));

endmodule

// File: rtl/msel_ovr_merge.sv
module msel_ovr_merge #(
   parameter int unsigned NUM_SLOTS = 7
) (
   input  logic [NUM_SLOTS-1:0] slot_n,
   input  logic                 shared_n,
   output logic                 claim
);

   generate
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("msel_ovr_merge: NUM_SLOTS must be at least 1");
      end
   endgenerate

   logic [NUM_SLOTS:0] chain;
   assign chain[0] = ~shared_n;

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         assign chain[s+1] = chain[s] | ~slot_n[s];
      end
   endgenerate

   assign claim = chain[NUM_SLOTS];

endmodule

// File: rtl/msel_decoder.sv
module msel_decoder
   import msel_pkg::*;
#(
   parameter int unsigned ADDR_W    = MSEL_ADDR_W,
   parameter int unsigned MIN_SHIFT = MSEL_MIN_SHIFT,
   parameter int unsigned SIZE_W    = MSEL_SIZE_W,
   parameter int unsigned NUM_SLOTS = MSEL_SLOTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [SIZE_W-1:0]    cfg_size,
   input  logic                 mem_strobe,
   input  logic                 io_cycle,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_SLOTS-1:0] slot_ovr_n,
   input  logic                 shared_ovr_n,
   output logic                 rom_cs_n,
   output logic                 ram_cs_n
);

   logic [SIZE_W-1:0] size_q;
   logic              rom_hit;
   logic              claim;
   logic              mem_active;
   msel_cs_t          cs;

   msel_size_reg #(.SIZE_W(SIZE_W)) u_size (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_data (cfg_size),
      .size_q  (size_q)
   );

   msel_rom_match #(.ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .SIZE_W(SIZE_W)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .size_q (size_q),
      .hit    (rom_hit)
   );

   msel_ovr_merge #(.NUM_SLOTS(NUM_SLOTS)) u_ovr (
      .slot_n   (slot_ovr_n),
      .shared_n (shared_ovr_n),
      .claim    (claim)
   );

   assign mem_active = mem_strobe & ~io_cycle;

   always_comb begin
      cs.rom_n = ~(mem_active & rom_hit);
      cs.ram_n = ~(mem_active & cs.rom_n & ~claim);
   end

   assign rom_cs_n = cs.rom_n;
   assign ram_cs_n = cs.ram_n;

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs_n || ram_cs_n);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_cycle || !mem_strobe) |-> (rom_cs_n && ram_cs_n));

   assert_slot_hole_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs_n |-> (&slot_ovr_n));

   assert_shared_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs_n |-> shared_ovr_n);

   assert_rom_deaf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(addr) && $stable(mem_strobe) && $stable(io_cycle) &&
       $stable(size_q) && !$stable({slot_ovr_n, shared_ovr_n}))
      |-> $stable(rom_cs_n));

endmodule

// File: tb/msel_decoder_test.sv
`timescale 1ns/100ps
module msel_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [8:0]  cfg_size = 9'h001;
   logic        mem_strobe = 1'b0;
   logic        io_cycle = 1'b0;
   logic [19:0] addr = '0;
   logic [6:0]  slot_ovr_n = 7'h7F;
   logic        shared_ovr_n = 1'b1;
   logic        rom_cs_n;
   logic        ram_cs_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   msel_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size(cfg_size),
      .mem_strobe(mem_strobe), .io_cycle(io_cycle), .addr(addr),
      .slot_ovr_n(slot_ovr_n), .shared_ovr_n(shared_ovr_n),
      .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
   );

   // row: {req, size, addr, mem, io, slot_n, shared_n, exp_rom_n, exp_ram_n}
   localparam int NV = 16;
   localparam logic [44:0] VEC [NV] = '{
      {4'd2,  9'h001, 20'hFFC00, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b0, 1'b1},
      {4'd5,  9'h001, 20'hFFBFF, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b1, 1'b0},
      {4'd3,  9'h040, 20'hF0000, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b0, 1'b1},
      {4'd3,  9'h040, 20'hEFFFF, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b1, 1'b0},
      {4'd3,  9'h100, 20'hC0000, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b0, 1'b1},
      {4'd3,  9'h100, 20'hBFFFF, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b1, 1'b0},
      {4'd3,  9'h080, 20'hE0000, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b0, 1'b1},
      {4'd3,  9'h080, 20'hDFFFF, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b1, 1'b0},
      {4'd5,  9'h001, 20'h00000, 1'b1, 1'b0, 7'h7F, 1'b1, 1'b1, 1'b0},
      {4'd6,  9'h001, 20'h12345, 1'b1, 1'b0, 7'h7E, 1'b1, 1'b1, 1'b1},
      {4'd6,  9'h001, 20'h12345, 1'b1, 1'b0, 7'h3F, 1'b1, 1'b1, 1'b1},
      {4'd7,  9'h001, 20'h40000, 1'b1, 1'b0, 7'h7F, 1'b0, 1'b1, 1'b1},
      {4'd8,  9'h001, 20'hFFFFF, 1'b1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1},
      {4'd8,  9'h040, 20'hF8000, 1'b1, 1'b0, 7'h55, 1'b0, 1'b0, 1'b1},
      {4'd9,  9'h001, 20'h12345, 1'b0, 1'b0, 7'h7F, 1'b1, 1'b1, 1'b1},
      {4'd9,  9'h001, 20'hFFFFF, 1'b1, 1'b1, 7'h7F, 1'b1, 1'b1, 1'b1}
   };

   function automatic string rname(input int r);
      case (r)
         1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
         5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
         9: return "R9";  default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic exp_rom, input logic exp_ram);
      checks++;
      if (rom_cs_n !== exp_rom || ram_cs_n !== exp_ram) begin
         fails++;
         $display("FAIL %s addr=%h rom/ram actual=%b%b expected=%b%b",
                  req, addr, rom_cs_n, ram_cs_n, exp_rom, exp_ram);
      end
   endtask

   task automatic write_size(input logic [8:0] sz);
      @(negedge clk);
      cfg_size = sz;
      cfg_wr   = 1'b1;
      @(negedge clk);
      cfg_wr   = 1'b0;
   endtask

   task automatic drive(input logic [19:0] a, input logic m, input logic io,
                        input logic [6:0] so, input logic sh);
      @(negedge clk);
      addr = a; mem_strobe = m; io_cycle = io; slot_ovr_n = so; shared_ovr_n = sh;
      #1;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset block size of 1 KB
      drive(20'hFFC00, 1'b1, 1'b0, 7'h7F, 1'b1); check("R1", 1'b0, 1'b1);
      drive(20'hFFBFF, 1'b1, 1'b0, 7'h7F, 1'b1); check("R1", 1'b1, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [44:0] v;
         v = VEC[i];
         write_size(v[40:32]);
         drive(v[31:12], v[11], v[10], v[9:3], v[2]);
         check(rname(int'(v[44:41])), v[1], v[0]);
         // R10: never both selected
         checks++;
         if (!rom_cs_n && !ram_cs_n) begin
            fails++;
            $display("FAIL R10 both low actual=%b%b expected not 00", rom_cs_n, ram_cs_n);
         end
      end

      // R6: each slot alone punches a hole
      write_size(9'h001);
      for (int s = 0; s < 7; s++) begin
         drive(20'h30000, 1'b1, 1'b0, ~(7'h01 << s), 1'b1);
         check("R6", 1'b1, 1'b1);
      end

      // R4: illegal writes keep the 64 KB block
      write_size(9'h040);
      write_size(9'h003);
      drive(20'hF0000, 1'b1, 1'b0, 7'h7F, 1'b1); check("R4", 1'b0, 1'b1);
      drive(20'hEFFFF, 1'b1, 1'b0, 7'h7F, 1'b1); check("R4", 1'b1, 1'b0);
      write_size(9'h000);
      drive(20'hF0000, 1'b1, 1'b0, 7'h7F, 1'b1); check("R4", 1'b0, 1'b1);
      drive(20'hEFFFF, 1'b1, 1'b0, 7'h7F, 1'b1); check("R4", 1'b1, 1'b0);

      // R2: lower edge for every legal size
      for (int k = 0; k < 9; k++) begin
         logic [19:0] base;
         base = 20'hFFFFF - ((20'h400 << k) - 20'd1);
         write_size(9'h001 << k);
         drive(base, 1'b1, 1'b0, 7'h7F, 1'b1);          check("R2", 1'b0, 1'b1);
         drive(base - 20'd1, 1'b1, 1'b0, 7'h7F, 1'b1);  check("R2", 1'b1, 1'b0);
      end

      // R1: reset returns to 1 KB
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      drive(20'hFF800, 1'b1, 1'b0, 7'h7F, 1'b1); check("R1", 1'b1, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule